// File: doc/BRIEF.md
# Hierarchical Master Interrupt Aggregator

This block sits above a set of interrupt groups, each of which presents a 32-bit vector of pending, enabled causes. It folds those vectors into one 32-bit master summary word through a fixed routing map. Some summary bits stand for a whole group. Others cover only the lower or the upper half-word of a group, so that two different sources sharing one group can be told apart at the top level. Bit 31 of the master word is the only bit software can write, and it acts as the global interrupt enable.

Evaluation is driven by a strobe that the surrounding logic raises whenever an event arrives or a group register is written. A write to the master word also counts as an evaluation request. When the global enable is set, every mapped summary bit is reloaded from the current level of its source. If at least one summary bit is then set and the message-capability control word selects the single basic format, one interrupt message is issued. The message carries the programmed address and data.

The message leaves on a valid/ready interface. Valid rises on the same clock edge that updates the summary. Address and data are captured on that edge and held steady until ready is seen high. Valid is never withdrawn before acceptance. Evaluations that qualify while a message is still waiting are merged into that message rather than queued.

Top module: `mirq_aggregator`

## Requirements
- R1: After reset the master word reads 0 (global enable off, all summary bits clear) and msg_valid is low.
- R2: Half-word routing: summary bit 0 is the OR of group 0 bits 15:0, bit 1 of group 0 bits 31:16, bit 2 of group 1 bits 15:0, bit 3 of group 1 bits 31:16, bit 4 of group 2 bits 15:0 and bit 6 of group 3 bits 15:0; the upper halves of groups 2 and 3 reach no summary bit.
- R3: Whole-group routing: summary bits 16, 17 and 18 are the OR of all 32 bits of groups 4, 5 and 6; bit 20 follows group 7, bit 22 group 8, bit 23 group 9 and bit 30 group 10; group 11 reaches no summary bit.
- R4: On an evaluation with the enable in effect, every mapped summary bit is set if its masked source is nonzero and cleared otherwise; the new value is visible after the clock edge that samples the request.
- R5: A master write changes only bit 31 (the enable); bits 30:0 of the written data are ignored, and the unmapped bits 5, 7-15, 19, 21 and 24-29 always read 0.
- R6: When the enable in effect is 0, an evaluation leaves bits 30:0 unchanged and sends no message. The enable in effect is the written bit 31 during a master write, and the stored bit otherwise.
- R7: A message is issued only when an evaluation runs with the enable set and at least one of summary bits 30:0 is set afterwards.
- R8: No message is issued while cap_ctrl bit 0 (message enable) is 0.
- R9: No message is issued while any of cap_ctrl bits 15:1 is nonzero.
- R10: Each qualifying evaluation raises msg_valid on the same edge as the summary update, with msg_addr = cap_addr and msg_data = cap_data sampled at that edge. While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data hold, and further qualifying evaluations merge into the waiting message. With msg_ready high, each message is valid for one cycle.
- R11: Pending vectors that change without an evaluation request leave the master word and msg_valid unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_pending | input | NUM_GROUPS*GROUP_W | Pending-and-enabled vectors, group g in bits g*GROUP_W upward |
| eval_strobe | input | 1 | Request to re-evaluate the summary |
| mreg_wr_en | input | 1 | Master word write; also an evaluation request |
| mreg_wr_data | input | 32 | Master write data; only bit 31 is taken |
| mreg_rd_data | output | 32 | Master word: enable in bit 31, summary in bits 30:0 |
| cap_ctrl | input | CTRL_W | Message control; bit 0 enable, bits 15:1 must be 0 |
| cap_addr | input | ADDR_W | Programmed message address |
| cap_data | input | MSG_DATA_W | Programmed message data |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted by the receiver |
| msg_addr | output | ADDR_W | Message address |
| msg_data | output | MSG_DATA_W | Message data |

## Verification
The bench builds the block with its defaults: twelve groups of 32 bits, a 32-bit message address and 16-bit message data. With these values every routed master bit is reachable. The same is true of both half-word splits, the spare twelfth group that must stay invisible, and every unmapped master position. Holding msg_ready low over several evaluations exercises the merge-and-hold path of the message interface.

// File: rtl/mirq_pkg.sv
package mirq_pkg;

  localparam int MASTER_W   = 32;
  localparam int ENABLE_BIT = 31;
  localparam int SUM_W      = 31;

  typedef enum logic [1:0] {
    SPAN_FULL = 2'd0,
    SPAN_LO   = 2'd1,
    SPAN_HI   = 2'd2
  } span_e;

  typedef struct packed {
    logic       used;
    logic [3:0] grp;
    span_e      span;
  } route_t;

  // Fixed routing of master summary bits onto source groups.
  function automatic route_t route_of(input int bit_idx);
    route_t r;
    r.used = 1'b1;
    r.grp  = 4'd0;
    r.span = SPAN_FULL;
    case (bit_idx)
      0:  begin r.grp = 4'd0;  r.span = SPAN_LO; end
      1:  begin r.grp = 4'd0;  r.span = SPAN_HI; end
      2:  begin r.grp = 4'd1;  r.span = SPAN_LO; end
      3:  begin r.grp = 4'd1;  r.span = SPAN_HI; end
      4:  begin r.grp = 4'd2;  r.span = SPAN_LO; end
      6:  begin r.grp = 4'd3;  r.span = SPAN_LO; end
      16: r.grp = 4'd4;
      17: r.grp = 4'd5;
      18: r.grp = 4'd6;
      20: r.grp = 4'd7;
      22: r.grp = 4'd8;
      23: r.grp = 4'd9;
      30: r.grp = 4'd10;
      default: r.used = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic [MASTER_W-1:0] mapped_bits();
    logic [MASTER_W-1:0] m;
    m = '0;
    for (int b = 0; b < SUM_W; b++) m[b] = route_of(b).used;
    return m;
  endfunction

endpackage

// File: rtl/mirq_route.sv
module mirq_route
  import mirq_pkg::*;
#(
  parameter int    GROUP_W = 32,
  parameter bit    LIVE    = 1'b1,
  parameter span_e SPAN    = SPAN_FULL
) (
  input  logic [GROUP_W-1:0] vec,
  output logic               hit
);

  localparam int HALF = GROUP_W / 2;

  function automatic logic [GROUP_W-1:0] span_mask();
    logic [GROUP_W-1:0] m;
    for (int i = 0; i < GROUP_W; i++) begin
      m[i] = (SPAN == SPAN_FULL) ||
             (SPAN == SPAN_LO && i <  HALF) ||
             (SPAN == SPAN_HI && i >= HALF);
    end
    return m;
  endfunction

  generate
    if (LIVE) begin : g_live
      localparam logic [GROUP_W-1:0] MASK = span_mask();
      assign hit = |(vec & MASK);
    end else begin : g_dead
      logic unused_vec;
      assign unused_vec = ^vec;
      assign hit = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/mirq_summary.sv
module mirq_summary
  import mirq_pkg::*;
#(
  parameter int NUM_GROUPS = 12,
  parameter int GROUP_W    = 32
) (
  input  logic [NUM_GROUPS*GROUP_W-1:0] pend_flat,
  output logic [SUM_W-1:0]              sum_vec
);

  // Spare groups and unrouted half-words are referenced here only.
  logic unused_spare;
  assign unused_spare = ^pend_flat;

  for (genvar b = 0; b < SUM_W; b++) begin : g_bit
    localparam route_t RT   = route_of(b);
    localparam bit     LIVE = RT.used && (int'(RT.grp) < NUM_GROUPS);
    localparam int     GSEL = LIVE ? int'(RT.grp) : 0;

    mirq_route #(
      .GROUP_W (GROUP_W),
      .LIVE    (LIVE),
      .SPAN    (RT.span)
    ) u_route (
      .vec (pend_flat[GSEL*GROUP_W +: GROUP_W]),
      .hit (sum_vec[b])
    );
  end

endmodule

// File: rtl/mirq_master.sv
module mirq_master
  import mirq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                eval_strobe,
  input  logic                wr_en,
  input  logic [MASTER_W-1:0] wr_data,
  input  logic [SUM_W-1:0]    sum_in,
  output logic                eval_go,
  output logic                any_next,
  output logic [MASTER_W-1:0] master_q
);

  localparam logic [MASTER_W-1:0] MAPPED = mapped_bits();

  logic             en_q;
  logic             en_nx;
  logic [SUM_W-1:0] bits_q;
  logic [SUM_W-1:0] bits_nx;
  logic             unused_wr;

  assign unused_wr = ^wr_data[SUM_W-1:0];

  always_comb begin
    en_nx   = wr_en ? wr_data[ENABLE_BIT] : en_q;
    eval_go = (eval_strobe | wr_en) & en_nx;
    bits_nx = eval_go ? sum_in : bits_q;
  end

  assign any_next = |bits_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      bits_q <= '0;
    end else begin
      en_q   <= en_nx;
      bits_q <= bits_nx;
    end
  end

  assign master_q = {en_q, bits_q};

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (master_q[SUM_W-1:0] & ~MAPPED[SUM_W-1:0]) == '0); // R5

  AST_FOLLOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    eval_go |=> bits_q == $past(sum_in)); // R4

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_nx |=> $stable(bits_q)); // R6

  AST_NO_REQ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(eval_strobe || wr_en) |=> $stable(master_q)); // R11

endmodule

// File: rtl/mirq_msg_out.sv
module mirq_msg_out #(
  parameter int CTRL_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int MSG_DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fire_req,
  input  logic [CTRL_W-1:0]     ctrl,
  input  logic [ADDR_W-1:0]     addr_in,
  input  logic [MSG_DATA_W-1:0] data_in,
  input  logic                  ready,
  output logic                  valid_q,
  output logic [ADDR_W-1:0]     addr_q,
  output logic [MSG_DATA_W-1:0] data_q
);

  logic cap_ok;
  logic fire;
  logic slot_free;

  // Only the single basic format: enable set, every other control bit clear.
  assign cap_ok    = ctrl[0] && (ctrl[CTRL_W-1:1] == '0);
  assign fire      = fire_req && cap_ok;
  assign slot_free = !valid_q || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (slot_free) begin
      valid_q <= fire;
      if (fire) begin
        addr_q <= addr_in;
        data_q <= data_in;
      end
    end
  end

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready) |=> (valid_q && $stable(addr_q) && $stable(data_q))); // R10

  AST_CTRL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_ok && slot_free) |=> !valid_q); // R8

  AST_FORMAT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[CTRL_W-1:1] != '0 && slot_free) |=> !valid_q); // R9

endmodule

// File: rtl/mirq_aggregator.sv
module mirq_aggregator
  import mirq_pkg::*;
#(
  parameter int NUM_GROUPS = 12,
  parameter int GROUP_W    = 32,
  parameter int CTRL_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int MSG_DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_GROUPS*GROUP_W-1:0] grp_pending,
  input  logic                          eval_strobe,
  input  logic                          mreg_wr_en,
  input  logic [MASTER_W-1:0]           mreg_wr_data,
  output logic [MASTER_W-1:0]           mreg_rd_data,
  input  logic [CTRL_W-1:0]             cap_ctrl,
  input  logic [ADDR_W-1:0]             cap_addr,
  input  logic [MSG_DATA_W-1:0]         cap_data,
  output logic                          msg_valid,
  input  logic                          msg_ready,
  output logic [ADDR_W-1:0]             msg_addr,
  output logic [MSG_DATA_W-1:0]         msg_data
);

  logic [SUM_W-1:0] sum_vec;
  logic             eval_go;
  logic             any_next;
  logic             fire_req;

  mirq_summary #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_W    (GROUP_W)
  ) u_summary (
    .pend_flat (grp_pending),
    .sum_vec   (sum_vec)
  );

  mirq_master u_master (
    .clk         (clk),
    .rst_n       (rst_n),
    .eval_strobe (eval_strobe),
    .wr_en       (mreg_wr_en),
    .wr_data     (mreg_wr_data),
    .sum_in      (sum_vec),
    .eval_go     (eval_go),
    .any_next    (any_next),
    .master_q    (mreg_rd_data)
  );

  assign fire_req = eval_go && any_next;

  mirq_msg_out #(
    .CTRL_W     (CTRL_W),
    .ADDR_W     (ADDR_W),
    .MSG_DATA_W (MSG_DATA_W)
  ) u_msg (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_req (fire_req),
    .ctrl     (cap_ctrl),
    .addr_in  (cap_addr),
    .data_in  (cap_data),
    .ready    (msg_ready),
    .valid_q  (msg_valid),
    .addr_q   (msg_addr),
    .data_q   (msg_data)
  );

  AST_MSG_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> (mreg_rd_data[ENABLE_BIT] && |mreg_rd_data[SUM_W-1:0])); // R7

  AST_OFF_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid && !(mreg_wr_en ? mreg_wr_data[ENABLE_BIT] : mreg_rd_data[ENABLE_BIT]))
      |=> !msg_valid); // R6

endmodule

// File: tb/tb_mirq_aggregator.sv
`timescale 1ns/1ps
module tb_mirq_aggregator;

  localparam int NG = 12;
  localparam int GW = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NG*GW-1:0] grp_pending;
  logic           eval_strobe = 1'b0;
  logic           mreg_wr_en = 1'b0;
  logic [31:0]    mreg_wr_data = '0;
  logic [31:0]    mreg_rd_data;
  logic [15:0]    cap_ctrl = 16'h0001;
  logic [31:0]    cap_addr = 32'hFEE0_1000;
  logic [15:0]    cap_data = 16'h4021;
  logic           msg_valid;
  logic           msg_ready = 1'b1;
  logic [31:0]    msg_addr;
  logic [15:0]    msg_data;

  logic [GW-1:0]  pend [NG];
  int             n_checks = 0;
  int             n_errors = 0;
  bit             done = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int g = 0; g < NG; g++) grp_pending[g*GW +: GW] = pend[g];
  end

  mirq_aggregator dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .grp_pending  (grp_pending),
    .eval_strobe  (eval_strobe),
    .mreg_wr_en   (mreg_wr_en),
    .mreg_wr_data (mreg_wr_data),
    .mreg_rd_data (mreg_rd_data),
    .cap_ctrl     (cap_ctrl),
    .cap_addr     (cap_addr),
    .cap_data     (cap_data),
    .msg_valid    (msg_valid),
    .msg_ready    (msg_ready),
    .msg_addr     (msg_addr),
    .msg_data     (msg_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected summary straight from the routing requirements.
  function automatic logic [30:0] exp_sum();
    logic [30:0] e;
    e = '0;
    e[0]  = |pend[0][15:0];
    e[1]  = |pend[0][31:16];
    e[2]  = |pend[1][15:0];
    e[3]  = |pend[1][31:16];
    e[4]  = |pend[2][15:0];
    e[6]  = |pend[3][15:0];
    e[16] = |pend[4];
    e[17] = |pend[5];
    e[18] = |pend[6];
    e[20] = |pend[7];
    e[22] = |pend[8];
    e[23] = |pend[9];
    e[30] = |pend[10];
    return e;
  endfunction

  task automatic clear_pend();
    for (int g = 0; g < NG; g++) pend[g] = '0;
  endtask

  // All tasks start and end at a falling edge.
  task automatic strobe();
    eval_strobe = 1'b1;
    @(negedge clk);
    eval_strobe = 1'b0;
  endtask

  task automatic mwrite(input logic [31:0] d);
    mreg_wr_en   = 1'b1;
    mreg_wr_data = d;
    @(negedge clk);
    mreg_wr_en   = 1'b0;
    mreg_wr_data = '0;
  endtask

  task automatic t_reset();
    chk("R1 master after reset", mreg_rd_data, 32'h0);
    chk("R1 msg_valid after reset", msg_valid, 1'b0);
  endtask

  task automatic t_disabled();
    pend[0] = 32'h1;
    strobe();
    chk("R6 disabled strobe keeps master", mreg_rd_data, 32'h0);
    chk("R6 disabled strobe no message", msg_valid, 1'b0);
  endtask

  task automatic t_enable_write();
    mwrite(32'hFFFF_FFFF);
    chk("R5 enable write evaluates", mreg_rd_data, 32'h8000_0001);
    chk("R7 message on enable with cause", msg_valid, 1'b1);
    chk("R10 message address", msg_addr, 32'hFEE0_1000);
    chk("R10 message data", msg_data, 16'h4021);
    @(negedge clk);
    chk("R10 one-cycle pulse with ready", msg_valid, 1'b0);
  endtask

  task automatic t_halfword();
    clear_pend();
    pend[0] = 32'h0001_0000; pend[1] = 32'h0000_8000;
    pend[2] = 32'hFFFF_0000; pend[3] = 32'h0001_0000;
    strobe();
    chk("R2 halves pattern A", mreg_rd_data, 32'h8000_0006);
    chk("R2 pattern A vs model", mreg_rd_data, {1'b1, exp_sum()});
    @(negedge clk);
    clear_pend();
    pend[1] = 32'h8000_0000; pend[2] = 32'h0000_0010; pend[3] = 32'h0000_4000;
    strobe();
    chk("R2 halves pattern B", mreg_rd_data, 32'h8000_0058);
    @(negedge clk);
  endtask

  task automatic t_fullgroups();
    clear_pend();
    pend[4] = 32'h8000_0000; pend[6] = 32'h1; pend[8] = 32'h100;
    pend[10] = 32'h10; pend[11] = 32'hFFFF_FFFF;
    strobe();
    chk("R3 whole groups pattern A", mreg_rd_data, 32'hC045_0000);
    @(negedge clk);
    clear_pend();
    pend[5] = 32'h2; pend[7] = 32'h0400_0000; pend[9] = 32'h8;
    strobe();
    chk("R3 whole groups pattern B", mreg_rd_data, 32'h8092_0000);
    @(negedge clk);
    clear_pend();
    pend[11] = 32'hFFFF_FFFF;
    strobe();
    chk("R3 spare group invisible", mreg_rd_data, 32'h8000_0000);
    chk("R7 no cause no message", msg_valid, 1'b0);
  endtask

  task automatic t_level_and_unmapped();
    for (int g = 0; g < NG; g++) pend[g] = 32'hFFFF_FFFF;
    strobe();
    chk("R5 unmapped bits stay zero", mreg_rd_data, 32'hC0D7_005F);
    @(negedge clk);
    clear_pend();
    strobe();
    chk("R4 bits clear with level", mreg_rd_data, 32'h8000_0000);
    chk("R7 no message when cleared", msg_valid, 1'b0);
  endtask

  task automatic t_no_strobe();
    pend[0] = 32'h0000_FFFF; pend[4] = 32'h1;
    repeat (3) @(negedge clk);
    chk("R11 pending without strobe", mreg_rd_data, 32'h8000_0000);
    chk("R11 no message without strobe", msg_valid, 1'b0);
  endtask

  task automatic t_write_mask();
    clear_pend();
    pend[0] = 32'h0000_FFFF;
    strobe();
    chk("R4 set from level", mreg_rd_data, 32'h8000_0001);
    @(negedge clk);
    mwrite(32'h7FFF_FFFF);
    chk("R5 write ignores low bits", mreg_rd_data, 32'h0000_0001);
    chk("R6 no message on disable", msg_valid, 1'b0);
    pend[0] = '0;
    strobe();
    chk("R6 disabled holds summary", mreg_rd_data, 32'h0000_0001);
    mwrite(32'h8000_0000);
    chk("R4 enable write reevaluates", mreg_rd_data, 32'h8000_0000);
  endtask

  task automatic t_ctrl_gate();
    clear_pend();
    pend[8] = 32'h1;
    cap_ctrl = 16'h0000;
    strobe();
    chk("R8 control enable clear", msg_valid, 1'b0);
    chk("R8 summary still updates", mreg_rd_data, 32'h8040_0000);
    cap_ctrl = 16'h0003;
    strobe();
    chk("R9 control bit1 set", msg_valid, 1'b0);
    cap_ctrl = 16'h8001;
    strobe();
    chk("R9 control bit15 set", msg_valid, 1'b0);
    cap_ctrl = 16'h0001;
    strobe();
    chk("R8 basic format sends", msg_valid, 1'b1);
    @(negedge clk);
  endtask

  task automatic t_backpressure();
    clear_pend();
    pend[10] = 32'h1;
    msg_ready = 1'b0;
    cap_addr = 32'hFEE0_2000; cap_data = 16'h0055;
    strobe();
    chk("R10 valid raised", msg_valid, 1'b1);
    cap_addr = 32'hFEE0_3000; cap_data = 16'h00AA;
    strobe();
    chk("R10 merge keeps valid", msg_valid, 1'b1);
    chk("R10 merge keeps address", msg_addr, 32'hFEE0_2000);
    repeat (2) @(negedge clk);
    chk("R10 held data", msg_data, 16'h0055);
    msg_ready = 1'b1;
    @(negedge clk);
    chk("R10 taken then low", msg_valid, 1'b0);
    strobe();
    chk("R10 next message", msg_valid, 1'b1);
    chk("R10 next address", msg_addr, 32'hFEE0_3000);
    @(negedge clk);
    chk("R10 next pulse ends", msg_valid, 1'b0);
  endtask

  initial begin
    clear_pend();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_enable_write();
    t_halfword();
    t_fullgroups();
    t_level_and_unmapped();
    t_no_strobe();
    t_write_mask();
    t_ctrl_gate();
    t_backpressure();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule